// File: doc/BRIEF.md
# Eight-bit bidirectional port register bank

This block is the register core of an eight-line parallel port expander. A serial front end, which is not part of the block, selects one of four registers with a 2-bit index, writes bytes with a one-cycle strobe, and pulses a sample strobe to freeze the readable value before shifting it out. The block keeps the direction, output-latch and input-polarity state. It synchronises the raw pin levels and drives a per-line enable and level for the pad.

Lines 1 to 7 are push-pull when set as outputs. Line 0 has an open-drain driver only: it can pull the wire low and otherwise releases it. Index 0 reads the synchronised pin levels, with inversion applied only to lines set as inputs. Index 1 reads back the output latch and never the wire. Index 2 is the polarity mask and index 3 is the direction mask.

Top module: `port_bank`

## Requirements
- R1: After reset, the output latch (index 1) reads 0x00, the polarity mask (index 2) reads 0xF0 and the direction mask (index 3) reads 0xFF, and all pins are released (oe_o = 0x00, od_pull_o = 0).
- R2: A write strobe with index 0 changes no register, and the value read back at indexes 1, 2 and 3 is unchanged.
- R3: A write strobe with index 1, 2 or 3 loads wdata_i into that register. The value is visible on pins and on read-back from the cycle after the strobe.
- R4: Reading index 1 returns the output latch, whatever the pin levels are.
- R5: In the direction mask, bit value 1 makes a line an input and bit value 0 makes it an output. For lines 1..7, oe_o[k] = ~dir[k] and out_o[k] = latch[k].
- R6: Line 0 never drives high (oe_o[0] = 0, out_o[0] = 0). od_pull_o is 1 only when dir[0] = 0 and latch[0] = 0.
- R7: Index 0 reads the pin level two cycles late (two-flop synchroniser). For line k the bit is XORed with pol[k] only when dir[k] = 1; for output lines the raw level is returned.
- R8: rdata_o is a holding register. It is loaded with the selected register's value on the cycle after sample_i and holds that value otherwise.
- R9: When sample_i and a write strobe fall in the same cycle, the captured byte holds the register contents from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_i | input | 2 | Register index (0 in, 1 out latch, 2 polarity, 3 direction) |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| sample_i | input | 1 | Capture strobe for rdata_o |
| pin_i | input | 8 | Raw pin levels |
| rdata_o | output | 8 | Captured read value |
| oe_o | output | 8 | Per-line drive enable |
| out_o | output | 8 | Per-line drive level |
| od_pull_o | output | 1 | Line 0 pull-down control |

## Verification
The capture strobe and a register write can occur in the same cycle. The bench provokes this by asserting sample and write together for each writable index with a data value unlike the current contents. The captured byte must equal the old contents, and a later sample must return the new value. The bench also sweeps every pin pattern against chosen polarity and direction masks, and compares index 0 with a value computed arithmetically.

// File: rtl/port_bank.sv
module port_bank #(
  parameter int W = 8,
  parameter logic [7:0] POL_RST = 8'hF0,
  parameter logic [7:0] DIR_RST = 8'hFF
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   sel_i,
  input  logic [W-1:0] wdata_i,
  input  logic         wr_i,
  input  logic         sample_i,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] rdata_o,
  output logic [W-1:0] oe_o,
  output logic [W-1:0] out_o,
  output logic         od_pull_o
);
  logic [W-1:0] lat_q, pol_q, dir_q, s1_q, s2_q, in_val, rd_mux;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      lat_q <= '0;
      pol_q <= POL_RST[W-1:0];
      dir_q <= DIR_RST[W-1:0];
    end else if (wr_i) begin
      case (sel_i)
        2'd1: lat_q <= wdata_i;
        2'd2: pol_q <= wdata_i;
        2'd3: dir_q <= wdata_i;
        default: ;
      endcase
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= pin_i;
      s2_q <= s1_q;
    end

  assign in_val = s2_q ^ (pol_q & dir_q);

  always_comb
    case (sel_i)
      2'd0: rd_mux = in_val;
      2'd1: rd_mux = lat_q;
      2'd2: rd_mux = pol_q;
      default: rd_mux = dir_q;
    endcase

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) rdata_o <= '0;
    else if (sample_i) rdata_o <= rd_mux;

  assign oe_o      = {~dir_q[W-1:1], 1'b0};
  assign out_o     = {lat_q[W-1:1], 1'b0};
  assign od_pull_o = ~dir_q[0] & ~lat_q[0];

  assert_rdata_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(sample_i) |-> $stable(rdata_o));
  assert_sel0_nowrite_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'd0) |=> ($stable(oe_o) && $stable(out_o) && $stable(od_pull_o)));
  assert_line0_nohigh_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o[0] && !out_o[0]);
  assert_od_release_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    od_pull_o |-> !out_o[0] && !oe_o[0]);
  assert_latch_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'd1) |=> out_o[W-1:1] == $past(wdata_i[W-1:1]));
  assert_dir_write_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && sel_i == 2'd3) |=> oe_o[W-1:1] == ~$past(wdata_i[W-1:1]));
endmodule

// File: tb/port_bank_test.sv
module port_bank_test;
  logic clk = 0, rst_n = 0, wr = 0, smp = 0;
  logic [1:0] sel = 0;
  logic [7:0] wd = 0, pin = 0, rd, oe, outv;
  logic odp;
  int nvec = 0, nbad = 0;

  always #2 clk = ~clk;

  port_bank uut (.clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .wdata_i(wd), .wr_i(wr),
    .sample_i(smp), .pin_i(pin), .rdata_o(rd), .oe_o(oe), .out_o(outv), .od_pull_o(odp));

  task automatic chk(input string r, input logic [7:0] a, input logic [7:0] e);
    nvec++;
    if (a !== e) begin nbad++; $display("FAIL %s actual=%h expected=%h", r, a, e); end
  endtask

  task automatic wrreg(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); sel = s; wd = d; wr = 1;
    @(negedge clk); wr = 0;
  endtask

  task automatic rdreg(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); sel = s; smp = 1;
    @(negedge clk); smp = 0; v = rd;
  endtask

  initial begin
    #400000; nbad++; $display("FAIL watchdog");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad); $finish;
  end

  initial begin
    logic [7:0] v, pol, dir;
    repeat (3) @(negedge clk); rst_n = 1;
    rdreg(1, v); chk("R1 out", v, 8'h00);
    rdreg(2, v); chk("R1 pol", v, 8'hF0);
    rdreg(3, v); chk("R1 dir", v, 8'hFF);
    chk("R1 oe", oe, 8'h00); chk("R1 od", {7'd0, odp}, 8'h00);
    wrreg(0, 8'h5A);
    rdreg(1, v); chk("R2 out", v, 8'h00);
    rdreg(2, v); chk("R2 pol", v, 8'hF0);
    rdreg(3, v); chk("R2 dir", v, 8'hFF);
    for (int k = 0; k < 256; k += 37) begin
      wrreg(1, k[7:0]); chk("R3 out pins", outv, {k[7:1], 1'b0});
      pin = ~k[7:0]; rdreg(1, v); chk("R4 latch readback", v, k[7:0]);
    end
    for (int d = 0; d < 256; d += 17) begin
      for (int l = 0; l < 2; l++) begin
        wrreg(3, d[7:0]); wrreg(1, {7'h55, l[0]});
        chk("R5 oe", oe, {~d[7:1], 1'b0});
        chk("R5 out", outv, {7'h55, 1'b0});
        chk("R6 od", {7'd0, odp}, {7'd0, ~d[0] & ~l[0]});
      end
    end
    for (int p = 0; p < 4; p++) begin
      pol = 8'h3C ^ p[7:0] * 8'h47; dir = 8'hA5 ^ p[7:0] * 8'h1B;
      wrreg(2, pol); wrreg(3, dir);
      for (int x = 0; x < 256; x++) begin
        @(negedge clk); pin = x[7:0];
        @(negedge clk); @(negedge clk);
        rdreg(0, v); chk("R7 input", v, x[7:0] ^ (pol & dir));
      end
    end
    pin = 8'h00; repeat (3) @(negedge clk);
    @(negedge clk); sel = 2'd0; smp = 1;
    pin = 8'hFF; @(negedge clk); smp = 0;
    chk("R7 sync delay", rd, 8'h00 ^ (pol & dir));
    @(negedge clk); sel = 2'd2; smp = 1; @(negedge clk); smp = 0; v = rd;
    wrreg(2, 8'h11); repeat (3) @(negedge clk);
    chk("R8 hold", rd, v);
    for (int s = 1; s < 4; s++) begin
      logic [7:0] old;
      rdreg(s[1:0], old);
      @(negedge clk); sel = s[1:0]; wd = ~old; wr = 1; smp = 1;
      @(negedge clk); wr = 0; smp = 0;
      chk("R9 old value", rd, old);
      rdreg(s[1:0], v); chk("R9 new value", v, ~old);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule